// File: doc/BRIEF.md
# Transition-Filtered Status Register Set

This block keeps a bank of status register sets, each of which watches a vector of live condition inputs. Every set samples its conditions once per clock. A per-bit rising-edge filter and a per-bit falling-edge filter decide which changes are recorded in a sticky event register. An enable mask then reduces the recorded events to one summary bit per set. Software reaches the sets through a small register bus. It can read the conditions and the events, and it can read or write the enable and both edge filters. A read of the event register clears it.

The summaries feed fixed bit positions of an 8-bit status byte. Two further bits of that byte come straight from external "not empty" flags for an error store and a message store. One bit is the OR of the other seven. Six sets are built: measurement, system, questionable, standard event, operation, and a user set. The user set's summary is chained into the top condition bit of the operation set, so it shows how a lower set cascades upward into the status byte.

Top module: `stat_block`

## Requirements
- R1: Reading address 0 of a set returns that set's current effective condition vector in the same cycle. For the operation set (index 4), bit W-1 is the OR of the external input bit and the user set's summary.
- R2: When a bit's rising filter (address 3) is 1, a 0-to-1 change of that condition bit between two consecutive clocks sets the matching event bit at the second clock.
- R3: When a bit's falling filter (address 4) is 1, a 1-to-0 change sets the matching event bit. When both filters are 1, either direction sets it. When both are 0, neither does.
- R4: An event bit stays 1 until the event register (address 1) of its set is read. That read returns the pre-clear value, and the bits read 0 from the next clock unless a new edge arrives.
- R5: Each set's summary is 1 exactly when some event bit and its enable bit (address 2) are both 1. The summaries appear in the status byte at these bits: measurement at bit 0, system at bit 1, questionable at bit 3, standard event at bit 5, operation at bit 7.
- R6: An edge that qualifies in the same cycle as a clearing read of its event register is latched, not lost.
- R7: Synchronous reset clears event and enable, sets the rising filter to all ones and clears the falling filter. Conditions that are held high through reset do not create events after reset.
- R8: Status byte bit 2 follows the error-available input and bit 4 follows the message-available input. Bit 6 is the OR of the other seven bits.
- R9: A rise of the user set (index 5) summary is seen by the operation set as a rise of condition bit W-1. With default filters, it latches there one clock later.
- R10: Set select 0..5 and addresses 0..4 form the map. Writes to address 0 or 1 have no effect. Reads of an unmapped address or set return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cond_i | input | 6*W | Live conditions, set k at bits k*W +: W |
| err_avail_i | input | 1 | Error store not empty |
| msg_avail_i | input | 1 | Message store not empty |
| sel_i | input | 3 | Set select |
| addr_i | input | 3 | Register address within the set |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (clears event on address 1) |
| wdata_i | input | W | Write data |
| rdata_o | output | W | Read data, combinational |
| stb_o | output | 8 | Status byte |

## Verification
The bench drives single-bit rises and falls under each filter setting: rising only, falling only, both, and neither. These tell apart the direction logic of each bit. It lands a clearing read on the same cycle as a fresh edge, which separates an edge that is kept from one that is dropped. It holds conditions high across reset, which exposes any spurious event at start-up. It raises the user set's summary, which proves that the cascade reaches the operation bit one cycle later. A long stretch of random conditions, accesses and flag inputs is then compared every clock against a behavioural model. That run covers mixed enable masks and all the status byte positions.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int NSET  = 6;
  localparam int SEL_W = 3;

  localparam int SI_MEAS = 0;
  localparam int SI_SYS  = 1;
  localparam int SI_QUES = 2;
  localparam int SI_EVT  = 3;
  localparam int SI_OPER = 4;
  localparam int SI_USER = 5;

  localparam int SB_MEAS = 0;
  localparam int SB_SYS  = 1;
  localparam int SB_ERR  = 2;
  localparam int SB_QUES = 3;
  localparam int SB_MSG  = 4;
  localparam int SB_EVT  = 5;
  localparam int SB_MSTR = 6;
  localparam int SB_OPER = 7;

  typedef enum logic [2:0] {
    RA_COND = 3'd0,
    RA_EVT  = 3'd1,
    RA_EN   = 3'd2,
    RA_PTR  = 3'd3,
    RA_NTR  = 3'd4
  } reg_addr_e;

  // master bit: OR of every other bit of the status byte
  function automatic logic master_of(input logic [7:0] b);
    logic [7:0] m;
    m = b;
    m[SB_MSTR] = 1'b0;
    return |m;
  endfunction
endpackage

// File: rtl/stat_edge_det.sv
module stat_edge_det #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  // tracks the input even during reset, so held-high conditions are not new edges
  always_ff @(posedge clk) prev_q <= cur_i;

  assign rise_o = cur_i & ~prev_q;
  assign fall_o = ~cur_i & prev_q;
endmodule

// File: rtl/stat_reg_set.sv
module stat_reg_set
  import stat_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cond_i,
  input  logic         wr_i,
  input  logic         rd_i,
  input  logic [2:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic         sum_o,
  output logic         clr_o,
  output logic [W-1:0] evt_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] ptr_o,
  output logic [W-1:0] ntr_o,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] rise, fall;
  logic [W-1:0] evt_q, en_q, ptr_q, ntr_q;

  function automatic logic [W-1:0] filt_hits(input logic [W-1:0] r, f, p, n);
    return (r & p) | (f & n);
  endfunction

  stat_edge_det #(.W(W)) u_edge (
    .clk   (clk),
    .cur_i (cond_i),
    .rise_o(rise),
    .fall_o(fall)
  );

  assign hit_o = filt_hits(rise, fall, ptr_q, ntr_q);
  assign clr_o = rd_i && (reg_addr_e'(addr_i) == RA_EVT);

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
      en_q  <= '0;
      ptr_q <= '1;
      ntr_q <= '0;
    end else begin
      evt_q <= (clr_o ? '0 : evt_q) | hit_o;
      if (wr_i) begin
        case (reg_addr_e'(addr_i))
          RA_EN:   en_q  <= wdata_i;
          RA_PTR:  ptr_q <= wdata_i;
          RA_NTR:  ntr_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr_e'(addr_i))
      RA_COND: rdata_o = cond_i;
      RA_EVT:  rdata_o = evt_q;
      RA_EN:   rdata_o = en_q;
      RA_PTR:  rdata_o = ptr_q;
      RA_NTR:  rdata_o = ntr_q;
      default: rdata_o = '0;
    endcase
  end

  assign sum_o = |(evt_q & en_q);
  assign evt_o = evt_q;
  assign en_o  = en_q;
  assign ptr_o = ptr_q;
  assign ntr_o = ntr_q;
endmodule

// File: rtl/stat_byte_build.sv
module stat_byte_build
  import stat_pkg::*;
(
  input  logic       meas_i,
  input  logic       sys_i,
  input  logic       ques_i,
  input  logic       evt_i,
  input  logic       oper_i,
  input  logic       err_i,
  input  logic       msg_i,
  output logic [7:0] stb_o
);
  logic [7:0] raw;

  always_comb begin
    raw          = '0;
    raw[SB_MEAS] = meas_i;
    raw[SB_SYS]  = sys_i;
    raw[SB_ERR]  = err_i;
    raw[SB_QUES] = ques_i;
    raw[SB_MSG]  = msg_i;
    raw[SB_EVT]  = evt_i;
    raw[SB_OPER] = oper_i;
    stb_o          = raw;
    stb_o[SB_MSTR] = master_of(raw);
  end
endmodule

// File: rtl/stat_block.sv
module stat_block
  import stat_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NSET*W-1:0]   cond_i,
  input  logic                err_avail_i,
  input  logic                msg_avail_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [2:0]          addr_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [W-1:0]        wdata_i,
  output logic [W-1:0]        rdata_o,
  output logic [7:0]          stb_o
);
  localparam logic [W-1:0] TOPBIT = W'(1) << (W - 1);

  logic [NSET-1:0]   sum_v, clr_vec;
  logic [NSET*W-1:0] cond_eff, evt_all, en_all, ptr_all, ntr_all, hit_all;
  logic [W-1:0]      rd_arr [NSET];

  for (genvar g = 0; g < NSET; g++) begin : g_set
    logic [W-1:0] ce;
    logic         hit_sel;
    assign hit_sel = (sel_i == SEL_W'(g));
    if (g == SI_OPER) begin : g_casc
      assign ce = cond_i[g*W +: W] | ({W{sum_v[SI_USER]}} & TOPBIT);
    end else begin : g_plain
      assign ce = cond_i[g*W +: W];
    end
    assign cond_eff[g*W +: W] = ce;

    stat_reg_set #(.W(W)) u_set (
      .clk    (clk),
      .rst    (rst),
      .cond_i (ce),
      .wr_i   (wr_i && hit_sel),
      .rd_i   (rd_i && hit_sel),
      .addr_i (addr_i),
      .wdata_i(wdata_i),
      .rdata_o(rd_arr[g]),
      .sum_o  (sum_v[g]),
      .clr_o  (clr_vec[g]),
      .evt_o  (evt_all[g*W +: W]),
      .en_o   (en_all[g*W +: W]),
      .ptr_o  (ptr_all[g*W +: W]),
      .ntr_o  (ntr_all[g*W +: W]),
      .hit_o  (hit_all[g*W +: W])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NSET; k++)
      if (sel_i == SEL_W'(k)) rdata_o = rd_arr[k];
  end

  stat_byte_build u_byte (
    .meas_i(sum_v[SI_MEAS]),
    .sys_i (sum_v[SI_SYS]),
    .ques_i(sum_v[SI_QUES]),
    .evt_i (sum_v[SI_EVT]),
    .oper_i(sum_v[SI_OPER]),
    .err_i (err_avail_i),
    .msg_i (msg_avail_i),
    .stb_o (stb_o)
  );
endmodule

// File: rtl/stat_block_chk.sv
module stat_block_chk
  import stat_pkg::*;
#(
  parameter int W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [NSET*W-1:0] cond_eff,
  input logic [NSET*W-1:0] evt_all,
  input logic [NSET*W-1:0] en_all,
  input logic [NSET*W-1:0] ptr_all,
  input logic [NSET*W-1:0] ntr_all,
  input logic [NSET*W-1:0] hit_all,
  input logic [NSET-1:0]   clr_vec,
  input logic              err_avail_i,
  input logic              msg_avail_i,
  input logic [7:0]        stb_o
);
  // R2: a qualified rise is reported as a hit
  p_rise_hit_r2: assert property (@(posedge clk) disable iff (rst)
    ((hit_all & cond_eff & ~$past(cond_eff) & ptr_all) == (cond_eff & ~$past(cond_eff) & ptr_all)));

  // R3: a qualified fall is reported as a hit
  p_fall_hit_r3: assert property (@(posedge clk) disable iff (rst)
    ((hit_all & ~cond_eff & $past(cond_eff) & ntr_all) == (~cond_eff & $past(cond_eff) & ntr_all)));

  // R4: without a clearing read, no event bit drops
  p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_vec == '0) |=> ((evt_all & $past(evt_all)) == $past(evt_all)));

  // R4: a clearing read with no new edge empties the set
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_vec[0] && hit_all[W-1:0] == '0) |=> (evt_all[W-1:0] == '0));

  // R6: an edge coincident with the clearing read survives
  p_edge_wins_r6: assert property (@(posedge clk) disable iff (rst)
    clr_vec[0] |=> ((evt_all[W-1:0] & $past(hit_all[W-1:0])) == $past(hit_all[W-1:0])));

  // R5: measurement summary bit agrees with its set's state
  p_summary_r5: assert property (@(posedge clk) disable iff (rst)
    stb_o[SB_MEAS] == |(evt_all[W-1:0] & en_all[W-1:0]));

  // R8: master bit and the two direct flags
  p_master_r8: assert property (@(posedge clk) disable iff (rst)
    stb_o[SB_MSTR] == (|stb_o[5:0] || stb_o[7]));
  p_direct_r8: assert property (@(posedge clk) disable iff (rst)
    (stb_o[SB_ERR] == err_avail_i) && (stb_o[SB_MSG] == msg_avail_i));

  // R7: register state after a reset cycle
  p_reset_r7: assert property (@(posedge clk)
    rst |=> (evt_all == '0 && en_all == '0 && ptr_all == '1 && ntr_all == '0));
endmodule

bind stat_block stat_block_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cond_eff   (cond_eff),
  .evt_all    (evt_all),
  .en_all     (en_all),
  .ptr_all    (ptr_all),
  .ntr_all    (ntr_all),
  .hit_all    (hit_all),
  .clr_vec    (clr_vec),
  .err_avail_i(err_avail_i),
  .msg_avail_i(msg_avail_i),
  .stb_o      (stb_o)
);

// File: tb/sim_stat_block.sv
`timescale 1ns/1ps
module sim_stat_block;
  localparam int W  = 8;
  localparam int NS = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS*W-1:0] cond = '0;
  logic          err = 1'b0, msg = 1'b0;
  logic [2:0]    sel = '0, addr = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic [7:0]    stb;

  int checks = 0, bad = 0;
  bit done = 0;
  string tag = "R7";

  always #2.5 clk = ~clk;

  stat_block #(.W(W)) u0 (
    .clk(clk), .rst(rst), .cond_i(cond), .err_avail_i(err), .msg_avail_i(msg),
    .sel_i(sel), .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .rdata_o(rdata), .stb_o(stb)
  );

  // behavioural model
  logic [W-1:0] m_evt [NS], m_en [NS], m_ptr [NS], m_ntr [NS], m_prev [NS], m_e [NS];

  function automatic logic m_sum(int k);
    return (m_evt[k] & m_en[k]) != 0;
  endfunction

  function automatic logic [W-1:0] m_cond(int k);
    logic [W-1:0] c;
    c = cond[k*W +: W];
    if (k == 4 && m_sum(5)) c[W-1] = 1'b1;
    return c;
  endfunction

  function automatic logic [7:0] m_stb();
    logic [7:0] b;
    b = {m_sum(4), 1'b0, m_sum(3), msg, m_sum(2), err, m_sum(1), m_sum(0)};
    b[6] = (b != 0);
    return b;
  endfunction

  function automatic logic [W-1:0] m_rdata();
    if (sel >= NS) return '0;
    case (addr)
      3'd0: return m_cond(sel);
      3'd1: return m_evt[sel];
      3'd2: return m_en[sel];
      3'd3: return m_ptr[sel];
      3'd4: return m_ntr[sel];
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < NS; k++) m_e[k] = m_cond(k);
    for (int k = 0; k < NS; k++) begin
      if (rst) begin
        m_evt[k] = '0; m_en[k] = '0; m_ptr[k] = '1; m_ntr[k] = '0;
      end else begin
        if (rd && sel == 3'(k) && addr == 3'd1) m_evt[k] = '0;
        m_evt[k] = m_evt[k] | (m_e[k] & ~m_prev[k] & m_ptr[k]) | (~m_e[k] & m_prev[k] & m_ntr[k]);
        if (wr && sel == 3'(k)) begin
          if (addr == 3'd2) m_en[k] = wdata;
          if (addr == 3'd3) m_ptr[k] = wdata;
          if (addr == 3'd4) m_ntr[k] = wdata;
        end
      end
      m_prev[k] = m_e[k];
    end
  end

  task automatic check(string r, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic compare();
    check({tag, " status byte"}, W'(stb), W'(m_stb()));
    check({tag, " read data"}, rdata, m_rdata());
  endtask

  // one clock: compare at the falling edge, then return for new inputs
  task automatic tick();
    @(negedge clk);
    compare();
    rd = 1'b0; wr = 1'b0;
  endtask

  task automatic wreg(int s, int a, logic [W-1:0] d);
    sel = 3'(s); addr = 3'(a); wdata = d; wr = 1'b1;
    tick();
  endtask

  task automatic rreg(int s, int a, logic [W-1:0] exp, string r);
    sel = 3'(s); addr = 3'(a); rd = 1'b1;
    #1;
    check(r, rdata, exp);
    compare();
    tick();
  endtask

  task automatic setc(int s, logic [W-1:0] v);
    cond[s*W +: W] = v;
    tick();
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      bad++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NS; k++) begin
      m_evt[k] = '0; m_en[k] = '0; m_ptr[k] = '1; m_ntr[k] = '0; m_prev[k] = '0;
    end
    cond[0 +: W] = 8'hA5;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick();
    // R7: reset values, conditions held high make no event
    tag = "R7";
    rreg(0, 1, 8'h00, "R7 event after reset");
    rreg(0, 3, 8'hFF, "R7 rising filter reset");
    rreg(0, 4, 8'h00, "R7 falling filter reset");
    rreg(0, 2, 8'h00, "R7 enable reset");
    // R1: condition mirror
    tag = "R1";
    cond[1*W +: W] = 8'h3C;
    rreg(1, 0, 8'h3C, "R1 condition read");
    cond[1*W +: W] = 8'hC3;
    rreg(1, 0, 8'hC3, "R1 condition follows");
    // R2: rising edge latch, summary to bit 0 (R5)
    tag = "R2";
    setc(0, 8'h00);
    rreg(0, 1, 8'h00, "R2 clear before rise");
    wreg(0, 2, 8'hFF);
    setc(0, 8'h02);
    check("R5 measurement summary bit0", W'(stb[0]), 8'h01);
    check("R8 master bit6", W'(stb[6]), 8'h01);
    rreg(0, 1, 8'h02, "R2 rise latched");
    // R3: falling filter, both, neither
    tag = "R3";
    wreg(0, 3, 8'h00);
    wreg(0, 4, 8'h02);
    setc(0, 8'h00);
    rreg(0, 1, 8'h02, "R3 fall latched");
    wreg(0, 3, 8'h04); wreg(0, 4, 8'h04);
    setc(0, 8'h04); rreg(0, 1, 8'h04, "R3 both rise");
    setc(0, 8'h00); rreg(0, 1, 8'h04, "R3 both fall");
    wreg(0, 3, 8'h00); wreg(0, 4, 8'h00);
    setc(0, 8'h0F); setc(0, 8'h00);
    rreg(0, 1, 8'h00, "R3 neither filter");
    // R4: sticky then clear on read
    tag = "R4";
    wreg(2, 2, 8'h10);
    setc(2, 8'h10);
    repeat (4) tick();
    check("R5 questionable bit3", W'(stb[3]), 8'h01);
    rreg(2, 1, 8'h10, "R4 sticky value");
    rreg(2, 1, 8'h00, "R4 cleared by read");
    check("R5 bit3 drops", W'(stb[3]), 8'h00);
    // R6: edge during clearing read
    tag = "R6";
    wreg(0, 3, 8'hFF);
    setc(0, 8'h01);
    cond[0 +: W] = 8'h03;
    rreg(0, 1, 8'h01, "R6 read old value");
    rreg(0, 1, 8'h02, "R6 edge kept");
    // R8: direct flags
    tag = "R8";
    err = 1'b1; #1;
    check("R8 error bit2", W'(stb[2]), 8'h01);
    msg = 1'b1; err = 1'b0; #1;
    check("R8 message bit4", W'(stb[4]), 8'h01);
    check("R8 master from message", W'(stb[6]), 8'h01);
    msg = 1'b0; tick();
    // R9: user set cascades into operation bit 7
    tag = "R9";
    wreg(4, 2, 8'h80);
    wreg(5, 2, 8'h01);
    setc(5, 8'h01);
    check("R9 operation bit not yet", W'(stb[7]), 8'h00);
    rreg(4, 0, 8'h80, "R9 user summary as condition");
    check("R9 operation bit7", W'(stb[7]), 8'h01);
    rreg(4, 1, 8'h80, "R9 operation event");
    // R10: map
    tag = "R10";
    wreg(3, 0, 8'hFF); wreg(3, 1, 8'hFF);
    rreg(3, 1, 8'h00, "R10 event write ignored");
    rreg(3, 0, 8'h00, "R10 condition write ignored");
    rreg(3, 7, 8'h00, "R10 unmapped address");
    rreg(7, 2, 8'h00, "R10 unmapped set");
    wreg(3, 2, 8'h01); wreg(3, 3, 8'h01);
    setc(3, 8'h01);
    check("R5 standard event bit5", W'(stb[5]), 8'h01);
    wreg(1, 2, 8'h80); setc(1, 8'h80);
    check("R5 system bit1", W'(stb[1]), 8'h01);
    // random mix against the model
    tag = "R5";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      cond = {$urandom, $urandom};
      err = 1'($urandom); msg = 1'($urandom);
      sel = 3'($urandom_range(0, 7));
      addr = 3'($urandom_range(0, 5));
      wdata = W'($urandom);
      if (r < 3) rd = 1'b1;
      else if (r < 5) wr = 1'b1;
      #1;
      compare();
      tick();
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule